// File: doc/BRIEF.md
# Statistics Counter Event Processor

This block keeps a bank of event counters that are updated through a queue instead of directly. Several producers can each raise a counter-increment request in the same cycle. Every request first enters a FIFO event queue. A small engine empties the queue one event at a time. For each event it reads the addressed counter and that counter's threshold entry, writes back the incremented value, and checks the new value against the threshold when the entry is armed.

When a counter reaches an armed threshold, the counter's index goes into a separate interrupt queue. An interrupt line stays high for as long as that queue holds entries, and the processor pops the entries one by one. A processor read port returns any counter's value. A destructive variant of the read clears the counter in the same access.

The counter and threshold storage is a register model. It stands in for the external memory that a full system would use.

Top module: `stat_event_engine`

## Requirements
- R1: After reset every counter reads 0, every threshold entry is unarmed, and `irq`, `ovf` and `rd_valid` are low.
- R2: Each queued event adds one to the counter named by its index. The engine spends two cycles per event: one to pop and one to write back. When the queue is empty and the engine is idle, an event captured at clock edge k is written at edge k+2. A read sampled at edge k+3 or later returns the new value.
- R3: Producers that raise requests in the same cycle are all queued while space remains, in ascending producer order. Every queued request adds one to its counter, so two requests for the same counter add two.
- R4: A request that finds the event queue already holding `EQ_DEPTH` entries is dropped. Its counter is not incremented, and `ovf` goes high and stays high until reset.
- R5: A counter at its maximum value 2^CNT_W-1 stays there on further events. It never wraps to 0.
- R6: When an increment makes a counter equal to its armed threshold level, the counter's index is appended to the interrupt queue. `irq` is high while that queue is not empty, and `iq_head` shows the oldest index. Entries leave the queue in the order they were added, one for each `iq_pop` cycle.
- R7: A counter whose threshold entry is unarmed (`thr_act` = 0 when it was written) adds nothing to the interrupt queue, even when its value equals the stored level.
- R8: A read with `rd_clr` = 0 gives `rd_valid` one cycle after `rd_req`. `rd_data` then holds the counter's value as it was at the request edge, and the counter is unchanged.
- R9: A read with `rd_clr` = 1 returns the value in the same way and sets the counter to 0.
- R10: A destructive read may fall in the same cycle as the engine's write-back to the same counter. In that case the read returns the value from before the increment, and the counter ends at 1, so the increment is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | NPROD | One increment request per producer |
| ev_idx | input | NPROD*IW | Counter index per producer; producer p uses bits [p*IW +: IW] |
| rd_req | input | 1 | Processor read request |
| rd_clr | input | 1 | Makes the read destructive |
| rd_idx | input | IW | Counter to read |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | CNT_W | Value read |
| thr_we | input | 1 | Writes one threshold entry |
| thr_idx | input | IW | Counter whose threshold is written |
| thr_level | input | CNT_W | Threshold level |
| thr_act | input | 1 | Arms the threshold entry |
| iq_pop | input | 1 | Removes the oldest interrupt queue entry |
| iq_head | output | IW | Oldest interrupt queue entry |
| irq | output | 1 | Interrupt queue not empty |
| ovf | output | 1 | Sticky event-queue overflow flag |

## Verification
Single isolated events separate a correct increment from a missing or doubled one. A read timed to the exact write-back edge pins the two-cycle engine latency. Same-cycle requests from both producers, first to one counter and then to two, show whether every queued entry is applied or only the first. Long runs of events to one counter separate saturation from wrap-around. Counters with armed and unarmed thresholds, reached in a chosen order, show whether the interrupt queue keeps crossing order and ignores unarmed entries. A destructive read that lands on the write-back cycle shows whether the clear and the increment both take effect. A sustained burst from both producers is used to fill the queue and raise the sticky overflow flag.

// File: rtl/stat_evt_pkg.sv
package stat_evt_pkg;
  typedef enum logic {ENG_FETCH = 1'b0, ENG_UPDATE = 1'b1} eng_state_e;
endpackage

// File: rtl/stat_evt_fifo.sv
// FIFO with several push lanes; lanes are accepted in ascending order while space remains.
module stat_evt_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  parameter int NPUSH = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPUSH-1:0]   push_vld,
  input  logic [NPUSH*W-1:0] push_dat,
  input  logic               pop,
  output logic [W-1:0]       head,
  output logic               empty,
  output logic               drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic [AW:0]   nacc;
  logic [NPUSH-1:0] acc;
  logic [AW-1:0] waddr [NPUSH];
  logic          pop_ok;

  always_comb begin
    logic [AW:0] slot;
    slot = cnt;
    nacc = '0;
    drop = 1'b0;
    for (int i = 0; i < NPUSH; i++) begin
      acc[i]   = 1'b0;
      waddr[i] = wptr + nacc[AW-1:0];
      if (push_vld[i]) begin
        if (slot < FULL_LVL) begin
          acc[i] = 1'b1;
          slot   = slot + 1'b1;
          nacc   = nacc + 1'b1;
        end else begin
          drop = 1'b1;
        end
      end
    end
  end

  assign empty  = (cnt == '0);
  assign pop_ok = pop & ~empty;
  assign head   = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      wptr <= '0;
      rptr <= '0;
    end else begin
      cnt  <= cnt + nacc - {{AW{1'b0}}, pop_ok};
      wptr <= wptr + nacc[AW-1:0];
      rptr <= rptr + {{(AW-1){1'b0}}, pop_ok};
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPUSH; i++) begin
      if (acc[i]) mem[waddr[i]] <= push_dat[i*W +: W];
    end
  end
endmodule

// File: rtl/stat_cnt_store.sv
// Counter and threshold storage; the engine write wins over a processor clear.
module stat_cnt_store #(
  parameter int NCNT  = 16,
  parameter int CNT_W = 16,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    eng_idx,
  input  logic             eng_we,
  input  logic [CNT_W-1:0] eng_val,
  output logic [CNT_W-1:0] eng_old,
  output logic [CNT_W-1:0] eng_lvl,
  output logic             eng_act,
  input  logic [IW-1:0]    cpu_idx,
  input  logic             cpu_clr,
  output logic [CNT_W-1:0] cpu_val,
  input  logic             thr_we,
  input  logic [IW-1:0]    thr_idx,
  input  logic [CNT_W-1:0] thr_level,
  input  logic             thr_act
);
  logic [CNT_W-1:0] cnt_q [NCNT];
  logic [CNT_W-1:0] lvl_q [NCNT];
  logic             act_q [NCNT];

  assign eng_old = cnt_q[eng_idx];
  assign eng_lvl = lvl_q[eng_idx];
  assign eng_act = act_q[eng_idx];
  assign cpu_val = cnt_q[cpu_idx];

  for (genvar g = 0; g < NCNT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
        lvl_q[g] <= '0;
        act_q[g] <= 1'b0;
      end else begin
        if (eng_we && eng_idx == IW'(g))       cnt_q[g] <= eng_val;
        else if (cpu_clr && cpu_idx == IW'(g)) cnt_q[g] <= '0;
        if (thr_we && thr_idx == IW'(g)) begin
          lvl_q[g] <= thr_level;
          act_q[g] <= thr_act;
        end
      end
    end
  end
endmodule

// File: rtl/stat_event_engine.sv
module stat_event_engine #(
  parameter int NPROD    = 2,
  parameter int NCNT     = 16,
  parameter int CNT_W    = 16,
  parameter int EQ_DEPTH = 8,
  parameter int IQ_DEPTH = 4,
  parameter int IW       = $clog2(NCNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPROD-1:0]    ev_valid,
  input  logic [NPROD*IW-1:0] ev_idx,
  input  logic                rd_req,
  input  logic                rd_clr,
  input  logic [IW-1:0]       rd_idx,
  output logic                rd_valid,
  output logic [CNT_W-1:0]    rd_data,
  input  logic                thr_we,
  input  logic [IW-1:0]       thr_idx,
  input  logic [CNT_W-1:0]    thr_level,
  input  logic                thr_act,
  input  logic                iq_pop,
  output logic [IW-1:0]       iq_head,
  output logic                irq,
  output logic                ovf
);
  import stat_evt_pkg::*;

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  function automatic logic crosses(input logic act, input logic [CNT_W-1:0] lvl,
                                   input logic [CNT_W-1:0] wr, input logic [CNT_W-1:0] old,
                                   input logic cleared);
    return act && (wr == lvl) && !(old == CMAX && !cleared);
  endfunction

  eng_state_e       state;
  logic [IW-1:0]    cur_idx;
  logic [IW-1:0]    eq_head;
  logic             eq_empty, eq_drop;
  logic             iq_empty, iq_lost;
  logic [CNT_W-1:0] old_val, new_val, lvl, cpu_val;
  logic             act;

  // named internal events
  logic evt_pop, cnt_wr, clr_hit, thr_hit;

  assign evt_pop = (state == ENG_FETCH) && !eq_empty;
  assign cnt_wr  = (state == ENG_UPDATE);
  assign clr_hit = cnt_wr && rd_req && rd_clr && (rd_idx == cur_idx);
  assign new_val = clr_hit ? CNT_W'(1) : bump(old_val);
  assign thr_hit = cnt_wr && crosses(act, lvl, new_val, old_val, clr_hit);

  stat_evt_fifo #(.W(IW), .DEPTH(EQ_DEPTH), .NPUSH(NPROD)) u_evq (
    .clk(clk), .rst_n(rst_n), .push_vld(ev_valid), .push_dat(ev_idx),
    .pop(evt_pop), .head(eq_head), .empty(eq_empty), .drop(eq_drop));

  stat_evt_fifo #(.W(IW), .DEPTH(IQ_DEPTH), .NPUSH(1)) u_irqq (
    .clk(clk), .rst_n(rst_n), .push_vld(thr_hit), .push_dat(cur_idx),
    .pop(iq_pop), .head(iq_head), .empty(iq_empty), .drop(iq_lost));

  stat_cnt_store #(.NCNT(NCNT), .CNT_W(CNT_W), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .eng_idx(cur_idx), .eng_we(cnt_wr), .eng_val(new_val),
    .eng_old(old_val), .eng_lvl(lvl), .eng_act(act),
    .cpu_idx(rd_idx), .cpu_clr(rd_req && rd_clr), .cpu_val(cpu_val),
    .thr_we(thr_we), .thr_idx(thr_idx), .thr_level(thr_level), .thr_act(thr_act));

  assign irq = !iq_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ENG_FETCH;
      cur_idx  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ovf      <= 1'b0;
    end else begin
      if (evt_pop) begin
        cur_idx <= eq_head;
        state   <= ENG_UPDATE;
      end else if (cnt_wr) begin
        state   <= ENG_FETCH;
      end
      rd_valid <= rd_req;
      if (rd_req) rd_data <= cpu_val;
      if (eq_drop) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/stat_event_engine_chk.sv
module stat_event_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_pop,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] new_val,
  input logic             thr_hit,
  input logic             iq_lost,
  input logic             irq,
  input logic             ovf,
  input logic             rd_req,
  input logic             rd_valid
);
  // R2
  pop_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n) evt_pop |=> cnt_wr);
  // R2
  no_pop_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_wr |-> !evt_pop);
  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_wr |-> new_val != '0);
  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n) thr_hit |=> irq);
  // R6
  iq_lost_chk: assert property (@(posedge clk) disable iff (!rst_n) iq_lost |-> irq);
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);
  // R8
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> rd_valid);
endmodule

bind stat_event_engine stat_event_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pop(evt_pop), .cnt_wr(cnt_wr), .new_val(new_val),
  .thr_hit(thr_hit), .iq_lost(iq_lost), .irq(irq), .ovf(ovf),
  .rd_req(rd_req), .rd_valid(rd_valid));

// File: tb/stat_event_engine_test.sv
module stat_event_engine_test;
  localparam int NP = 2, NC = 16, CW = 4, IW = 4, CMAX = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NP-1:0]    ev_valid = '0;
  logic [NP*IW-1:0] ev_idx = '0;
  logic             rd_req = 1'b0, rd_clr = 1'b0;
  logic [IW-1:0]    rd_idx = '0;
  logic             rd_valid;
  logic [CW-1:0]    rd_data;
  logic             thr_we = 1'b0, thr_act = 1'b0;
  logic [IW-1:0]    thr_idx = '0;
  logic [CW-1:0]    thr_level = '0;
  logic             iq_pop = 1'b0;
  logic [IW-1:0]    iq_head;
  logic             irq, ovf;

  stat_event_engine #(.NPROD(NP), .NCNT(NC), .CNT_W(CW), .EQ_DEPTH(8), .IQ_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_idx(ev_idx),
    .rd_req(rd_req), .rd_clr(rd_clr), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .thr_we(thr_we), .thr_idx(thr_idx), .thr_level(thr_level), .thr_act(thr_act),
    .iq_pop(iq_pop), .iq_head(iq_head), .irq(irq), .ovf(ovf));

  int checks = 0, errors = 0;
  int mdl [NC];
  int tlvl [NC];
  bit tact [NC];
  int exp_q [$];
  string tag_q [$];
  int iq_exp [$];
  bit direct = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic void apply_inc(input int idx);
    int old, nw;
    old = mdl[idx];
    nw = (old == CMAX) ? old : old + 1;
    if (tact[idx] && nw == tlvl[idx] && old != CMAX) iq_exp.push_back(idx);
    mdl[idx] = nw;
  endfunction

  // scoreboard monitor for read responses
  always @(negedge clk) begin
    if (rst_n && rd_valid && !direct) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected read", int'(rd_data), -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(rd_data) == e, t, int'(rd_data), e);
      end
    end
  end

  task automatic send1(input int idx);
    @(negedge clk);
    ev_valid = 2'b01;
    ev_idx[IW-1:0] = IW'(idx);
    apply_inc(idx);
    @(negedge clk);
    ev_valid = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send2(input int a, input int b);
    @(negedge clk);
    ev_valid = 2'b11;
    ev_idx[IW-1:0] = IW'(a);
    ev_idx[IW +: IW] = IW'(b);
    apply_inc(a);
    apply_inc(b);
    @(negedge clk);
    ev_valid = '0;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd(input int idx, input bit clr, input string tag);
    @(negedge clk);
    rd_req = 1'b1;
    rd_clr = clr;
    rd_idx = IW'(idx);
    exp_q.push_back(mdl[idx]);
    tag_q.push_back(tag);
    if (clr) mdl[idx] = 0;
    @(negedge clk);
    rd_req = 1'b0;
    rd_clr = 1'b0;
  endtask

  task automatic set_thr(input int idx, input int lvl, input bit act);
    @(negedge clk);
    thr_we = 1'b1;
    thr_idx = IW'(idx);
    thr_level = CW'(lvl);
    thr_act = act;
    tlvl[idx] = lvl;
    tact[idx] = act;
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic pop_iq(input string tag);
    int e;
    @(negedge clk);
    chk(irq == 1'b1, tag, int'(irq), 1);
    if (iq_exp.size() == 0) chk(1'b0, tag, int'(iq_head), -1);
    else begin
      e = iq_exp.pop_front();
      chk(int'(iq_head) == e, tag, int'(iq_head), e);
    end
    iq_pop = 1'b1;
    @(negedge clk);
    iq_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      mdl[i] = 0; tlvl[i] = 0; tact[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(ovf == 1'b0, "R1 ovf", int'(ovf), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    for (int i = 0; i < NC; i++) rd(i, 1'b0, "R1 counter");

    // R2 single events
    send1(3); send1(3); send1(3); send1(7);
    rd(3, 1'b0, "R2 count");
    rd(7, 1'b0, "R2 count");
    // R2 timing: read sampled at third edge after capture
    @(negedge clk);
    ev_valid = 2'b01; ev_idx[IW-1:0] = IW'(9); apply_inc(9);
    @(negedge clk);
    ev_valid = '0;
    @(negedge clk);
    rd(9, 1'b0, "R2 timing");
    repeat (3) @(negedge clk);

    // R3 same-cycle producers
    send2(4, 4);
    send2(5, 6);
    rd(4, 1'b0, "R3 same counter");
    rd(5, 1'b0, "R3 lane0");
    rd(6, 1'b0, "R3 lane1");

    // R6 threshold crossing
    set_thr(2, 3, 1'b1);
    send1(2); send1(2);
    chk(irq == 1'b0, "R6 early", int'(irq), 0);
    send1(2);
    chk(irq == 1'b1, "R6 raise", int'(irq), 1);
    pop_iq("R6 entry");
    @(negedge clk);
    chk(irq == 1'b0, "R6 drained", int'(irq), 0);
    set_thr(10, 1, 1'b1);
    set_thr(11, 1, 1'b1);
    send1(11);
    send1(10);
    pop_iq("R6 order first");
    pop_iq("R6 order second");
    @(negedge clk);
    chk(irq == 1'b0, "R6 empty", int'(irq), 0);

    // R7 unarmed threshold
    set_thr(12, 1, 1'b0);
    send1(12);
    chk(irq == 1'b0, "R7 irq", int'(irq), 0);
    chk(iq_exp.size() == 0, "R7 model", iq_exp.size(), 0);
    rd(12, 1'b0, "R7 count");

    // R5 saturation
    repeat (20) send1(13);
    rd(13, 1'b0, "R5 saturate");

    // R8 plain reads keep the value
    rd(7, 1'b0, "R8 first");
    rd(7, 1'b0, "R8 second");

    // R9 destructive read
    rd(3, 1'b1, "R9 value");
    rd(3, 1'b0, "R9 cleared");

    // R10 clear colliding with write-back
    repeat (5) send1(14);
    @(negedge clk);
    ev_valid = 2'b01; ev_idx[IW-1:0] = IW'(14);
    @(negedge clk);
    ev_valid = '0;
    @(negedge clk);
    rd_req = 1'b1; rd_clr = 1'b1; rd_idx = IW'(14);
    exp_q.push_back(mdl[14]);
    tag_q.push_back("R10 pre-increment");
    mdl[14] = 0;
    apply_inc(14);
    @(negedge clk);
    rd_req = 1'b0; rd_clr = 1'b0;
    repeat (3) @(negedge clk);
    rd(14, 1'b0, "R10 kept increment");
    repeat (3) @(negedge clk);

    // R4 overflow
    chk(ovf == 1'b0, "R4 before", int'(ovf), 0);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      ev_valid = 2'b11;
      ev_idx[IW-1:0] = IW'(15);
      ev_idx[IW +: IW] = IW'(15);
    end
    @(negedge clk);
    ev_valid = '0;
    repeat (40) @(negedge clk);
    chk(ovf == 1'b1, "R4 flag", int'(ovf), 1);
    direct = 1'b1;
    @(negedge clk);
    rd_req = 1'b1; rd_clr = 1'b0; rd_idx = IW'(15);
    @(negedge clk);
    rd_req = 1'b0;
    chk(int'(rd_data) >= 8, "R4 accepted count", int'(rd_data), 8);
    @(negedge clk);
    direct = 1'b0;
    repeat (10) @(negedge clk);
    chk(ovf == 1'b1, "R4 sticky", int'(ovf), 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 pending reads", exp_q.size(), 0);
    finish_run();
  end
endmodule